// File: doc/BRIEF.md
# Single-Cycle Stack Machine Core

This block is a small stack-based processor that completes one instruction on every clock edge. Its state is a program counter, an operand stack with its own pointer, and a variable store. Code memory, stack and store each hold 2^ADDR_W entries. An instruction is a 4-bit opcode followed by a VAL_W-bit value field. That field carries a constant, a store index or a branch distance, depending on the opcode.

Software loads code through a write port, normally while reset is held, and then releases reset so the core runs from address 0. Every instruction reads the state as it stood at the start of its cycle. All of its updates (pc, stack pointer, stack entry, store entry) land together at the next edge. A stack, index or branch case that the finite memories cannot represent does not execute. Instead the core raises `fault` and stops. The `halt` opcode parks the machine and raises `halted`. A debug port gives a combinational read of any store entry.

Top module: `ssm_core`

## Requirements
- R1: An instruction word is {opcode[VAL_W+3:VAL_W], value[VAL_W-1:0]}. The opcodes are 0 const, 1 var, 2 setvar, 3 add, 4 sub, 5 bfwd, 6 bbwd, 7 beq, 8 bne, 9 blt, 10 bge and 15 halt.
- R2: const pushes the value field and var pushes store[value]. Both then advance pc by one.
- R3: setvar pops the top entry (at sp-1) into store[value], decrements sp and advances pc by one.
- R4: add and sub pop n2 (the top) and then n1, push n1+n2 or n1-n2 modulo 2^VAL_W, and advance pc by one.
- R5: bfwd sets pc to pc+1+value and bbwd sets pc to pc+1-value. Neither touches the stack.
- R6: The conditional branches pop n2 and then n1 and compare them unsigned (eq, ne, n1<n2, n1>=n2). If the condition holds, pc becomes pc+1+value. Otherwise pc becomes pc+1.
- R7: halt changes no state, raises `halted`, and the core stays there until reset.
- R8: An instruction that pops more entries than the stack holds raises `fault` and writes neither stack nor store.
- R9: A push while the stack already holds 2^ADDR_W entries raises `fault`. The stack pointer never exceeds 2^ADDR_W.
- R10: The following raise `fault` without executing: an opcode of 11 to 14, a var or setvar index of 2^ADDR_W or more, and a next pc outside code memory (including a negative backward target). `halted` and `fault` are never both high.
- R11: Once `fault` is high, pc, sp, stack and store stay frozen until reset. Synchronous reset clears pc, sp, `halted` and `fault` but keeps the contents of code memory and store.
- R12: While `ld_en` is high, code[ld_addr] takes ld_data at each edge and no instruction executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Code write strobe; stalls execution |
| ld_addr | input | ADDR_W | Code memory write address |
| ld_data | input | VAL_W+4 | Instruction word to write |
| dbg_addr | input | ADDR_W | Store read address |
| dbg_data | output | VAL_W | Store entry at dbg_addr (combinational) |
| halted | output | 1 | Core has executed halt |
| fault | output | 1 | Core stopped on a rejected instruction |

## Verification
The bench goes after the places where the pc and stack-pointer arithmetic are easiest to get wrong. It pushes the 33rd entry into a 32-deep stack, where a wrapping pointer would silently overwrite entry 0 instead of faulting. It pops from an empty stack, which should fault with the store left untouched; a design that pops anyway writes garbage. It runs a subtraction that borrows, and conditional branches whose operands sit in swapped order, where mixing up n1 and n2 flips the outcome. A forward branch lands just past an illegal word, so a branch computed from pc instead of pc+1 faults. It also stalls a running program with a code write and checks that no instruction slips through during the stall. Finally it resets after a halt and reruns the program without reloading, which catches a reset that clears code memory.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   localparam logic [3:0] OPC_CONST  = 4'd0;
   localparam logic [3:0] OPC_VAR    = 4'd1;
   localparam logic [3:0] OPC_SETVAR = 4'd2;
   localparam logic [3:0] OPC_ADD    = 4'd3;
   localparam logic [3:0] OPC_SUB    = 4'd4;
   localparam logic [3:0] OPC_BFWD   = 4'd5;
   localparam logic [3:0] OPC_BBWD   = 4'd6;
   localparam logic [3:0] OPC_BEQ    = 4'd7;
   localparam logic [3:0] OPC_BNE    = 4'd8;
   localparam logic [3:0] OPC_BLT    = 4'd9;
   localparam logic [3:0] OPC_BGE    = 4'd10;
   localparam logic [3:0] OPC_HALT   = 4'd15;

   // comparison selector for conditional branches
   localparam logic [1:0] CMP_EQ = 2'd0;
   localparam logic [1:0] CMP_NE = 2'd1;
   localparam logic [1:0] CMP_LT = 2'd2;
   localparam logic [1:0] CMP_GE = 2'd3;

   // source of a pushed word
   localparam logic [1:0] SRC_IMM = 2'd0;
   localparam logic [1:0] SRC_VAR = 2'd1;
   localparam logic [1:0] SRC_ALU = 2'd2;

   typedef struct packed {
      logic       legal;
      logic [1:0] pops;
      logic       push;
      logic [1:0] src;
      logic       alu_sub;
      logic       st_wr;
      logic       use_idx;
      logic       br_fwd;
      logic       br_bwd;
      logic       br_cond;
      logic [1:0] cmp;
      logic       is_halt;
   } ctl_t;

endpackage

// File: rtl/ssm_ram.sv
module ssm_ram #(
   parameter int AW  = 5,
   parameter int DW  = 8,
   parameter int NRD = 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [DW-1:0]     wd,
   input  logic [NRD*AW-1:0] ra,
   output logic [NRD*DW-1:0] rd
);

   localparam int ENTRIES = 1 << AW;

   logic [DW-1:0] mem [0:ENTRIES-1];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   for (genvar i = 0; i < NRD; i++) begin : g_rd
      assign rd[i*DW +: DW] = mem[ra[i*AW +: AW]];
   end

endmodule

// File: rtl/ssm_decode.sv
module ssm_decode
   import ssm_pkg::*;
(
   input  logic [3:0] opc,
   output ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      unique case (opc)
         OPC_CONST: begin
            ctl.legal = 1'b1;
            ctl.push  = 1'b1;
            ctl.src   = SRC_IMM;
         end
         OPC_VAR: begin
            ctl.legal   = 1'b1;
            ctl.push    = 1'b1;
            ctl.src     = SRC_VAR;
            ctl.use_idx = 1'b1;
         end
         OPC_SETVAR: begin
            ctl.legal   = 1'b1;
            ctl.pops    = 2'd1;
            ctl.st_wr   = 1'b1;
            ctl.use_idx = 1'b1;
         end
         OPC_ADD, OPC_SUB: begin
            ctl.legal   = 1'b1;
            ctl.pops    = 2'd2;
            ctl.push    = 1'b1;
            ctl.src     = SRC_ALU;
            ctl.alu_sub = (opc == OPC_SUB);
         end
         OPC_BFWD: begin
            ctl.legal  = 1'b1;
            ctl.br_fwd = 1'b1;
         end
         OPC_BBWD: begin
            ctl.legal  = 1'b1;
            ctl.br_bwd = 1'b1;
         end
         OPC_BEQ, OPC_BNE, OPC_BLT, OPC_BGE: begin
            ctl.legal   = 1'b1;
            ctl.pops    = 2'd2;
            ctl.br_cond = 1'b1;
            ctl.cmp     = (opc == OPC_BEQ) ? CMP_EQ :
                          (opc == OPC_BNE) ? CMP_NE :
                          (opc == OPC_BLT) ? CMP_LT : CMP_GE;
         end
         OPC_HALT: begin
            ctl.legal   = 1'b1;
            ctl.is_halt = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/ssm_exec.sv
module ssm_exec
   import ssm_pkg::*;
#(
   parameter int A = 5,
   parameter int V = 8
) (
   input  ctl_t         ctl,
   input  logic [V-1:0] imm,
   input  logic [A-1:0] pc,
   input  logic [A:0]   sp,
   input  logic [V-1:0] tos,
   input  logic [V-1:0] nos,
   input  logic [V-1:0] vrd,
   output logic [A-1:0] tos_a,
   output logic [A-1:0] nos_a,
   output logic         bad,
   output logic         halt_req,
   output logic [A-1:0] pc_nxt,
   output logic [A:0]   sp_nxt,
   output logic         stk_we,
   output logic [A-1:0] stk_wa,
   output logic [V-1:0] stk_wd,
   output logic         st_we,
   output logic [A-1:0] st_wa,
   output logic [V-1:0] st_wd
);

   localparam int W = ((A > V) ? A : V) + 2;
   localparam logic [A+1:0] DEPTH_W = {2'b01, {A{1'b0}}};
   localparam logic [W-1:0] LIM_W   = {{(W-A-1){1'b0}}, 1'b1, {A{1'b0}}};
   localparam logic [W-1:0] ONE_W   = {{(W-1){1'b0}}, 1'b1};

   logic         underflow, overflow, idx_bad, tgt_bad;
   logic [A+1:0] sp_after;
   logic [W-1:0] pc_w, imm_w, pc1, tgt_f, tgt_b, tgt;
   logic         bwd_neg, cond_true, take_fwd;
   logic [V-1:0] alu;

   // stack operand addresses (top and next-to-top)
   assign tos_a = sp[A-1:0] - {{(A-1){1'b0}}, 1'b1};
   assign nos_a = sp[A-1:0] - {{(A-2){1'b0}}, 2'd2};

   // stack depth checks
   assign underflow = ({1'b0, sp} < {{A{1'b0}}, ctl.pops});
   assign sp_after  = {1'b0, sp} - {{A{1'b0}}, ctl.pops} + {{(A+1){1'b0}}, ctl.push};
   assign overflow  = !underflow && (sp_after > DEPTH_W);

   // store index range check; only needed when the value field is wider
   if (V > A) begin : g_idx_wide
      assign idx_bad = ctl.use_idx & (|imm[V-1:A]);
   end else begin : g_idx_exact
      assign idx_bad = 1'b0;
   end

   // branch condition on n1 (deeper) and n2 (top)
   always_comb begin
      unique case (ctl.cmp)
         CMP_EQ:  cond_true = (nos == tos);
         CMP_NE:  cond_true = (nos != tos);
         CMP_LT:  cond_true = (nos <  tos);
         default: cond_true = (nos >= tos);
      endcase
   end

   // next pc in a widened domain so that out-of-range targets are visible
   assign pc_w     = {{(W-A){1'b0}}, pc};
   assign imm_w    = {{(W-V){1'b0}}, imm};
   assign pc1      = pc_w + ONE_W;
   assign tgt_f    = pc1 + imm_w;
   assign tgt_b    = pc1 - imm_w;
   assign bwd_neg  = (imm_w > pc1);
   assign take_fwd = ctl.br_fwd | (ctl.br_cond & cond_true);
   assign tgt      = ctl.br_bwd ? tgt_b : (take_fwd ? tgt_f : pc1);
   assign tgt_bad  = !ctl.is_halt && ((ctl.br_bwd && bwd_neg) || (tgt >= LIM_W));

   assign alu = ctl.alu_sub ? (nos - tos) : (nos + tos);

   assign bad      = !ctl.legal | underflow | overflow | idx_bad | tgt_bad;
   assign halt_req = ctl.is_halt;
   assign pc_nxt   = tgt[A-1:0];
   assign sp_nxt   = sp_after[A:0];

   assign stk_we = ctl.push & !bad;
   assign stk_wa = sp[A-1:0] - {{(A-2){1'b0}}, ctl.pops};
   always_comb begin
      unique case (ctl.src)
         SRC_IMM: stk_wd = imm;
         SRC_VAR: stk_wd = vrd;
         default: stk_wd = alu;
      endcase
   end

   assign st_we = ctl.st_wr & !bad;
   assign st_wa = imm[A-1:0];
   assign st_wd = tos;

endmodule

// File: rtl/ssm_core.sv
module ssm_core
   import ssm_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int VAL_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [VAL_W+3:0]  ld_data,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic [VAL_W-1:0]  dbg_data,
   output logic              halted,
   output logic              fault
);

   localparam int IW = VAL_W + 4;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ssm_core: ADDR_W must be at least 2");
   end
   if (VAL_W < ADDR_W) begin : g_bad_val
      $error("ssm_core: VAL_W must be at least ADDR_W");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W:0]   sp_q;
   logic              halted_q, fault_q;
   logic              run;

   logic [IW-1:0]        instr;
   ctl_t                 ctl;
   logic [ADDR_W-1:0]    tos_a, nos_a, pc_nxt, stk_wa, st_wa;
   logic [ADDR_W:0]      sp_nxt;
   logic [VAL_W-1:0]     tos, nos, vrd, stk_wd, st_wd;
   logic [2*VAL_W-1:0]   stk_rd, st_rd;
   logic                 bad, halt_req, stk_we, st_we;

   assign run = !rst && !ld_en && !halted_q && !fault_q;

   ssm_ram #(.AW(ADDR_W), .DW(IW), .NRD(1)) u_code (
      .clk (clk),
      .we  (ld_en),
      .wa  (ld_addr),
      .wd  (ld_data),
      .ra  (pc_q),
      .rd  (instr)
   );

   ssm_ram #(.AW(ADDR_W), .DW(VAL_W), .NRD(2)) u_stack (
      .clk (clk),
      .we  (run && stk_we),
      .wa  (stk_wa),
      .wd  (stk_wd),
      .ra  ({nos_a, tos_a}),
      .rd  (stk_rd)
   );
   assign tos = stk_rd[VAL_W-1:0];
   assign nos = stk_rd[2*VAL_W-1:VAL_W];

   ssm_ram #(.AW(ADDR_W), .DW(VAL_W), .NRD(2)) u_store (
      .clk (clk),
      .we  (run && st_we),
      .wa  (st_wa),
      .wd  (st_wd),
      .ra  ({dbg_addr, st_wa}),
      .rd  (st_rd)
   );
   assign vrd      = st_rd[VAL_W-1:0];
   assign dbg_data = st_rd[2*VAL_W-1:VAL_W];

   ssm_decode u_dec (
      .opc (instr[IW-1:VAL_W]),
      .ctl (ctl)
   );

   ssm_exec #(.A(ADDR_W), .V(VAL_W)) u_exec (
      .ctl      (ctl),
      .imm      (instr[VAL_W-1:0]),
      .pc       (pc_q),
      .sp       (sp_q),
      .tos      (tos),
      .nos      (nos),
      .vrd      (vrd),
      .tos_a    (tos_a),
      .nos_a    (nos_a),
      .bad      (bad),
      .halt_req (halt_req),
      .pc_nxt   (pc_nxt),
      .sp_nxt   (sp_nxt),
      .stk_we   (stk_we),
      .stk_wa   (stk_wa),
      .stk_wd   (stk_wd),
      .st_we    (st_we),
      .st_wa    (st_wa),
      .st_wd    (st_wd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= '0;
         sp_q     <= '0;
         halted_q <= 1'b0;
         fault_q  <= 1'b0;
      end else if (run) begin
         if (bad) begin
            fault_q <= 1'b1;
         end else if (halt_req) begin
            halted_q <= 1'b1;
         end else begin
            pc_q <= pc_nxt;
            sp_q <= sp_nxt;
         end
      end
   end

   assign halted = halted_q;
   assign fault  = fault_q;

endmodule

// File: rtl/ssm_core_chk.sv
module ssm_core_chk #(
   parameter int A = 5
) (
   input logic         clk,
   input logic         rst,
   input logic         ld_en,
   input logic         halted,
   input logic         fault,
   input logic [A-1:0] pc,
   input logic [A:0]   sp
);

   localparam logic [A:0] DEPTH = {1'b1, {A{1'b0}}};

   // R11
   fault_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      fault |=> (fault && $stable(pc) && $stable(sp)));

   // R7
   halt_park_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc) && $stable(sp)));

   // R9
   sp_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
      sp <= DEPTH);

   // R12
   load_stall_chk: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> ($stable(pc) && $stable(sp)));

   // R10
   stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(halted && fault));

endmodule

bind ssm_core ssm_core_chk #(.A(ADDR_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .ld_en  (ld_en),
   .halted (halted),
   .fault  (fault),
   .pc     (pc_q),
   .sp     (sp_q)
);

// File: tb/ssm_core_tb.sv
module ssm_core_tb;

   localparam int A     = 5;
   localparam int V     = 8;
   localparam int DEPTH = 1 << A;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ld_en = 1'b0;
   logic [A-1:0] ld_addr = '0;
   logic [V+3:0] ld_data = '0;
   logic [A-1:0] dbg_addr = '0;
   logic [V-1:0] dbg_data;
   logic         halted, fault;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   string cur_req = "R11";

   // reference model state
   int m_code [DEPTH];
   int m_stk  [DEPTH];
   int m_st   [DEPTH];
   bit m_ok   [DEPTH];
   int m_pc, m_sp;
   bit m_halt, m_fault;

   always #10 clk = ~clk;

   ssm_core #(.ADDR_W(A), .VAL_W(V)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (ld_en),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .dbg_addr (dbg_addr),
      .dbg_data (dbg_data),
      .halted   (halted),
      .fault    (fault)
   );

   function automatic int enc(int op, int d);
      return ((op & 15) << V) | (d & ((1 << V) - 1));
   endfunction

   task automatic model_step();
      int op, d, n1, n2, npc;
      bit bad, cond;
      op = m_code[m_pc] >> V;
      d = m_code[m_pc] & ((1 << V) - 1);
      bad = 0; n1 = 0; n2 = 0; cond = 0;
      npc = m_pc + 1;
      case (op)
         0: if (m_sp >= DEPTH) bad = 1;
         1: if (d >= DEPTH || m_sp >= DEPTH) bad = 1;
         2: if (d >= DEPTH || m_sp < 1) bad = 1;
         3, 4, 7, 8, 9, 10: begin
            if (m_sp < 2) bad = 1;
            else begin
               n2 = m_stk[m_sp-1];
               n1 = m_stk[m_sp-2];
            end
         end
         5: npc = m_pc + 1 + d;
         6: npc = m_pc + 1 - d;
         15: ;
         default: bad = 1;
      endcase
      if (op == 7) cond = (n1 == n2);
      if (op == 8) cond = (n1 != n2);
      if (op == 9) cond = (n1 < n2);
      if (op == 10) cond = (n1 >= n2);
      if (cond) npc = m_pc + 1 + d;
      if (op != 15 && (npc < 0 || npc >= DEPTH)) bad = 1;
      if (bad) m_fault = 1;
      else if (op == 15) m_halt = 1;
      else begin
         case (op)
            0: begin m_stk[m_sp] = d; m_sp++; end
            1: begin m_stk[m_sp] = m_st[d]; m_sp++; end
            2: begin m_st[d] = m_stk[m_sp-1]; m_ok[d] = 1; m_sp--; end
            3: begin m_stk[m_sp-2] = (n1 + n2) & 255; m_sp--; end
            4: begin m_stk[m_sp-2] = (n1 - n2) & 255; m_sp--; end
            7, 8, 9, 10: m_sp -= 2;
            default: ;
         endcase
         m_pc = npc;
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_pc = 0; m_sp = 0; m_halt = 0; m_fault = 0;
      end else if (!ld_en && !m_halt && !m_fault) begin
         model_step();
      end
   end

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (cmp_on) begin
         chk(cur_req, "halted", int'(halted), int'(m_halt));
         chk(cur_req, "fault", int'(fault), int'(m_fault));
         if (m_ok[dbg_addr]) chk(cur_req, "store", int'(dbg_data), m_st[dbg_addr]);
      end
      dbg_addr = dbg_addr + 1'b1;
   endtask

   task automatic rd_store(int a, output int v);
      dbg_addr = A'(a);
      #1;
      v = int'(dbg_data);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick();
      tick();
   endtask

   task automatic load(int prog[$]);
      foreach (prog[i]) begin
         ld_en = 1'b1;
         ld_addr = A'(i);
         ld_data = (V+4)'(prog[i]);
         m_code[i] = prog[i];
         tick();
      end
      ld_en = 1'b0;
   endtask

   task automatic run_prog(int limit);
      rst = 1'b0;
      for (int n = 0; n < limit; n++) begin
         tick();
         if (m_halt || m_fault) break;
      end
      tick();
      tick();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R7 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      int p_fib[$], p_mix[$], p_und[$], p_ovf[$], p_ill[$], p_idx[$], p_tgt[$], p_stl[$];
      for (int i = 0; i < DEPTH; i++) begin
         m_code[i] = 0; m_stk[i] = 0; m_st[i] = 0; m_ok[i] = 0;
      end
      m_pc = 0; m_sp = 0; m_halt = 0; m_fault = 0;

      // Fibonacci loop: a=s0, b=s1, cnt=s2, t=s3
      p_fib = '{enc(0,0), enc(2,0), enc(0,1), enc(2,1), enc(0,10), enc(2,2),
                enc(1,0), enc(1,1), enc(3,0), enc(2,3),
                enc(1,1), enc(2,0), enc(1,3), enc(2,1),
                enc(1,2), enc(0,1), enc(4,0), enc(2,2),
                enc(1,2), enc(0,0), enc(7,1), enc(6,16), enc(15,0)};
      p_mix = '{enc(0,3), enc(0,5), enc(4,0), enc(2,4),
                enc(0,3), enc(0,5), enc(9,2), enc(0,1), enc(2,5), enc(0,7), enc(2,5),
                enc(0,5), enc(0,3), enc(10,2), enc(0,1), enc(2,6), enc(0,8), enc(2,6),
                enc(0,4), enc(0,4), enc(8,2), enc(0,2), enc(2,7),
                enc(5,1), enc(12,0), enc(0,6), enc(2,8), enc(15,0)};
      p_und = '{enc(2,8)};
      p_ovf = '{enc(0,1), enc(6,2)};
      p_ill = '{enc(0,3), enc(2,10), enc(11,0)};
      p_idx = '{enc(0,1), enc(2,40)};
      p_tgt = '{enc(5,40)};
      p_stl = '{enc(0,0), enc(2,11), enc(0,7), enc(2,11), enc(15,0)};

      do_reset();
      cmp_on = 1;
      cur_req = "R11";
      chk("R11", "reset halted", int'(halted), 0);
      chk("R11", "reset fault", int'(fault), 0);

      // Fibonacci
      load(p_fib);
      cur_req = "R2 R3 R4 R5 R6";
      run_prog(1000);
      rd_store(0, v); chk("R2", "fib a", v, 55);
      rd_store(1, v); chk("R4", "fib b", v, 89);
      rd_store(2, v); chk("R6", "loop count", v, 0);
      rd_store(3, v); chk("R3", "fib t", v, 89);
      chk("R7", "halted", int'(halted), 1);
      cur_req = "R7";
      for (int i = 0; i < 5; i++) tick();
      chk("R7", "still halted", int'(halted), 1);
      rd_store(1, v); chk("R7", "store unchanged", v, 89);

      // reset keeps code memory; rerun without reload
      cur_req = "R11";
      do_reset();
      chk("R11", "halted cleared", int'(halted), 0);
      chk("R11", "fault cleared", int'(fault), 0);
      run_prog(1000);
      chk("R11", "rerun halted", int'(halted), 1);
      rd_store(0, v); chk("R11", "rerun a", v, 55);

      // sub wrap, unsigned compares, forward skip over illegal word
      do_reset();
      load(p_mix);
      cur_req = "R1 R4 R5 R6";
      run_prog(200);
      rd_store(4, v); chk("R4", "3-5 wraps", v, 254);
      rd_store(5, v); chk("R6", "blt taken", v, 7);
      rd_store(6, v); chk("R6", "bge taken", v, 8);
      rd_store(7, v); chk("R6", "bne not taken", v, 2);
      rd_store(8, v); chk("R5", "bfwd from pc+1", v, 6);
      chk("R1", "no fault", int'(fault), 0);
      chk("R1", "halted", int'(halted), 1);

      // underflow on empty stack
      do_reset();
      load(p_und);
      cur_req = "R8";
      run_prog(50);
      chk("R8", "underflow fault", int'(fault), 1);
      rd_store(8, v); chk("R8", "store untouched", v, 6);
      cur_req = "R11";
      for (int i = 0; i < 4; i++) tick();
      chk("R11", "fault sticky", int'(fault), 1);
      chk("R11", "not halted", int'(halted), 0);

      // overflow after 2^A pushes
      do_reset();
      load(p_ovf);
      cur_req = "R9";
      run_prog(500);
      chk("R9", "overflow fault", int'(fault), 1);
      chk("R9", "not halted", int'(halted), 0);

      // illegal opcode
      do_reset();
      load(p_ill);
      cur_req = "R10";
      run_prog(50);
      chk("R10", "illegal opcode fault", int'(fault), 1);
      rd_store(10, v); chk("R10", "prior setvar", v, 3);

      // index beyond store
      do_reset();
      load(p_idx);
      run_prog(50);
      chk("R10", "index fault", int'(fault), 1);

      // branch target outside code
      do_reset();
      load(p_tgt);
      run_prog(50);
      chk("R10", "target fault", int'(fault), 1);

      // code write stalls execution
      do_reset();
      load(p_stl);
      cur_req = "R12";
      rst = 1'b0;
      tick();
      tick();
      ld_en = 1'b1;
      ld_addr = A'(3);
      ld_data = (V+4)'(enc(2,12));
      m_code[3] = enc(2,12);
      for (int i = 0; i < 6; i++) tick();
      ld_en = 1'b0;
      chk("R12", "no halt while stalled", int'(halted), 0);
      rd_store(11, v); chk("R12", "no write while stalled", v, 0);
      run_prog(50);
      rd_store(12, v); chk("R12", "new word executed", v, 7);
      rd_store(11, v); chk("R12", "old slot kept", v, 0);
      chk("R12", "halted", int'(halted), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule